// File: doc/BRIEF.md
# Extended capability list walker

This block searches the chain of PCI Express extended capability headers held in a 4 KB configuration memory. The chain always begins at byte offset 0x100. Each header word holds three fields: a 16-bit capability ID, a 4-bit version and a 12-bit link to the next header. A client gives a capability ID with a one-cycle request. The walker reads one header per step through a synchronous 32-bit read port, then follows the links. It reports the offset where the ID was found and the offset of the entry before it. If the ID is absent it reports a miss.

ID 0 is reserved and never names a real capability. A search for ID 0 returns the last entry of the chain, meaning the one whose link is 0. A caller uses this to find the append point for a new capability. The walker does not trust the memory contents. A link that leaves the legal window or is not word aligned stops the walk with an error. A chain longer than a configurable number of visits also stops with an error, which catches cyclic lists.

Top module: `ecap_walker`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `found`, `err` and `mem_rd_en` are 0, and `hit_ofs` and `prev_ofs` are 0.
- R2: A header word is split as follows. The ID is in bits 15:0, the version in bits 19:16 and the next offset in bits 31:20. The version never takes part in the ID compare.
- R3: The walk starts at offset 0x100. If the header word there is all zero, the list is empty. The result is then `found`=0, `err`=0, `hit_ofs`=0 and `prev_ofs`=0, for any requested ID, including 0.
- R4: For a nonzero ID, the first entry whose ID matches gives `found`=1, with `hit_ofs` set to that entry's offset. `prev_ofs` is set to the previous entry's offset, or to 0 when the match is the entry at 0x100. The match is taken before the entry's link is checked.
- R5: For a nonzero ID, reaching an entry whose next offset is 0 without a match gives `found`=0, `err`=0 and `hit_ofs`=0, with `prev_ofs` set to that last entry's offset.
- R6: A search for ID 0 on a nonempty list gives `found`=1, with `hit_ofs` set to the first entry whose next offset is 0 and `prev_ofs` set to its predecessor. The IDs of the entries do not matter in this search.
- R7: A nonzero next offset is legal only if it lies in 0x100..0xFF8 inclusive and is a multiple of 4. 0xFF8 itself is legal. An illegal link ends the walk with `err`=1 and `found`=0. `hit_ofs` is then the entry holding the bad link and `prev_ofs` is that entry's predecessor. No read is ever issued below offset 0x100.
- R8: At most `MAX_VISITS` headers (default 1024) are read per search. If the walk would need one more header, it ends with `err`=1 and `found`=0. `hit_ofs` is then the last entry read and `prev_ofs` is that entry's predecessor.
- R9: Each visited entry costs one cycle with `mem_rd_en`=1 and `mem_addr`=offset/4, followed by one compare cycle. `done` pulses for one cycle on the 2n-th rising edge after the edge that accepted the request, where n is the number of headers read.
- R10: `req_valid` is ignored while `busy` is 1. The outputs `found`, `err`, `hit_ofs` and `prev_ofs` hold their values from `done` until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a search; taken only while idle |
| req_id | input | 16 | Capability ID to find; 0 selects the list tail |
| busy | output | 1 | A search is in progress |
| mem_rd_en | output | 1 | Read strobe to the configuration memory |
| mem_addr | output | 10 | Word address of the header being read |
| mem_rdata | input | 32 | Header word, valid the cycle after the strobe |
| done | output | 1 | One-cycle pulse marking a new result |
| found | output | 1 | The ID (or the tail) was located |
| err | output | 1 | Walk stopped on a bad link or on the visit limit |
| hit_ofs | output | 12 | Byte offset of the located or offending entry |
| prev_ofs | output | 12 | Byte offset of the preceding entry (0 if none) |

## Verification
A corrupted current-offset or predecessor register shows up at the port `mem_addr` on the very next read strobe. It also shows up at `hit_ofs` or `prev_ofs` when `done` rises, at most two cycles later. A broken visit count or loop control appears as a change in the `done` latency, which is checked on every search. A cyclic chain tests the visit limit directly. The random chains come with searches for present IDs, absent IDs and the tail, so every decision branch is reached with both a head entry and deeper entries.

// File: rtl/ecw_pkg.sv
// Shared constants and types for the extended capability list walker.
// Assumes a 4 KB configuration space addressed in bytes by 12 bits.
package ecw_pkg;
    localparam int OFS_W  = 12;
    localparam int ID_W   = 16;
    localparam int VER_W  = 4;
    localparam int WORD_W = ID_W + VER_W + OFS_W;

    localparam logic [OFS_W-1:0] EXT_BASE = 12'h100;
    localparam logic [OFS_W-1:0] EXT_LAST = 12'hFF8;

    // Header word layout, most significant field first.
    typedef struct packed {
        logic [OFS_W-1:0] nxt;
        logic [VER_W-1:0] ver;
        logic [ID_W-1:0]  id;
    } ecw_hdr_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_CMP  = 2'd2
    } ecw_state_e;
endpackage

// File: rtl/ecw_hdr_check.sv
// Combinational decode of one header word against the searched key.
// Assumes the word is the one just returned by the memory read.
// The outputs tell the sequencer which way the walk goes.
module ecw_hdr_check
    import ecw_pkg::*;
(
    input  logic [WORD_W-1:0] hdr_word,
    input  logic [ID_W-1:0]   want_id,
    input  logic              first_entry,
    output logic              is_empty,
    output logic              is_match,
    output logic              is_tail,
    output logic              link_bad
);
    ecw_hdr_t hdr;

    // Present the raw word as named fields.
    assign hdr = ecw_hdr_t'(hdr_word);

    // An all-zero word at the chain start means no capabilities exist.
    assign is_empty = first_entry && (hdr_word == '0);

    // A zero link closes the chain.
    assign is_tail = (hdr.nxt == '0);

    // A reserved key asks for the tail; otherwise compare the ID only.
    assign is_match = (want_id == '0) ? is_tail : (hdr.id == want_id);

    // A link must be word aligned and stay inside the extended window.
    assign link_bad = (hdr.nxt[1:0] != 2'b00) ||
                      (hdr.nxt < EXT_BASE)    ||
                      (hdr.nxt > EXT_LAST);
endmodule

// File: rtl/ecw_visit_ctr.sv
// Counts header reads in the current search and flags when the limit is reached.
// Assumes clear and step are never asserted together.
module ecw_visit_ctr #(
    parameter int MAX_VISITS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic at_limit
);
    localparam int CW = $clog2(MAX_VISITS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_VISITS);

    logic [CW-1:0] cnt;

    // Restart at each accepted request, advance on each header read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_limit = (cnt == LIMIT);

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);

    // R8
    visit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !at_limit);
endmodule

// File: rtl/ecap_walker.sv
// Sequencer that walks the extended capability chain starting at 0x100.
// Each step is one read cycle followed by one compare cycle. The result
// is published with a one-cycle done pulse and then held.
// Assumes the memory returns the addressed word one cycle after the strobe.
module ecap_walker
    import ecw_pkg::*;
#(
    parameter int MAX_VISITS = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ID_W-1:0]     req_id,
    output logic                busy,
    output logic                mem_rd_en,
    output logic [OFS_W-3:0]    mem_addr,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                done,
    output logic                found,
    output logic                err,
    output logic [OFS_W-1:0]    hit_ofs,
    output logic [OFS_W-1:0]    prev_ofs
);
    localparam int WA_W = OFS_W - 2;
    localparam logic [WA_W-1:0] BASE_WA = EXT_BASE[OFS_W-1:2];

    ecw_state_e         state;
    logic [ID_W-1:0]    key;
    logic [WA_W-1:0]    cur_wa;
    logic [OFS_W-1:0]   cur_ofs;
    logic [OFS_W-1:0]   prv_ofs;

    logic is_empty, is_match, is_tail, link_bad, at_limit;
    logic accept;
    logic fin_now, fin_found, fin_err;
    logic [OFS_W-1:0] fin_hit, fin_prev;

    assign cur_ofs   = {cur_wa, 2'b00};
    assign accept    = (state == ST_IDLE) && req_valid;
    assign busy      = (state != ST_IDLE);
    assign mem_rd_en = (state == ST_READ);
    assign mem_addr  = cur_wa;

    ecw_hdr_check u_hdr_check (
        .hdr_word    (mem_rdata),
        .want_id     (key),
        .first_entry (prv_ofs == '0),
        .is_empty    (is_empty),
        .is_match    (is_match),
        .is_tail     (is_tail),
        .link_bad    (link_bad)
    );

    ecw_visit_ctr #(.MAX_VISITS(MAX_VISITS)) u_visit_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .step     (mem_rd_en),
        .at_limit (at_limit)
    );

    // Decide in the compare cycle whether the walk ends and with what result.
    always_comb begin
        fin_now   = 1'b0;
        fin_found = 1'b0;
        fin_err   = 1'b0;
        fin_hit   = '0;
        fin_prev  = '0;
        if (state == ST_CMP) begin
            fin_now = 1'b1;
            if (is_empty) begin
                fin_now = 1'b1;
            end else if (is_match) begin
                fin_found = 1'b1;
                fin_hit   = cur_ofs;
                fin_prev  = prv_ofs;
            end else if (is_tail) begin
                fin_prev  = cur_ofs;
            end else if (link_bad || at_limit) begin
                fin_err   = 1'b1;
                fin_hit   = cur_ofs;
                fin_prev  = prv_ofs;
            end else begin
                fin_now   = 1'b0;
            end
        end
    end

    // Walk sequencer: accept, read, compare, then either follow the link or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            key     <= '0;
            cur_wa  <= BASE_WA;
            prv_ofs <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        key     <= req_id;
                        cur_wa  <= BASE_WA;
                        prv_ofs <= '0;
                        state   <= ST_READ;
                    end
                end
                ST_READ: begin
                    state <= ST_CMP;
                end
                ST_CMP: begin
                    if (fin_now) begin
                        state <= ST_IDLE;
                    end else begin
                        prv_ofs <= cur_ofs;
                        cur_wa  <= mem_rdata[WORD_W-1:WORD_W-WA_W];
                        state   <= ST_READ;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Result registers: pulse done and capture the outcome when the walk ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            found    <= 1'b0;
            err      <= 1'b0;
            hit_ofs  <= '0;
            prev_ofs <= '0;
        end else begin
            done <= fin_now;
            if (fin_now) begin
                found    <= fin_found;
                err      <= fin_err;
                hit_ofs  <= fin_hit;
                prev_ofs <= fin_prev;
            end
        end
    end

    // R9
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rd_en, 2));

    // R7
    addr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_addr >= BASE_WA));

    // R4
    hit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (hit_ofs >= EXT_BASE && hit_ofs <= EXT_LAST && hit_ofs[1:0] == 2'b00));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> ($stable(hit_ofs) && $stable(prev_ofs) && $stable(found) && $stable(err)));
endmodule

// File: tb/test_ecap_walker.sv
module test_ecap_walker;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_VIS    = 1024;
    localparam int WAIT_CAP   = 4 * MAX_VIS + 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [15:0] req_id;
    logic        busy;
    logic        mem_rd_en;
    logic [9:0]  mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic        found;
    logic        err;
    logic [11:0] hit_ofs;
    logic [11:0] prev_ofs;

    logic [31:0] mem [0:1023];
    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Synchronous configuration memory model.
    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

    ecap_walker #(.MAX_VISITS(MAX_VIS)) i_ecap_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
        .busy(busy), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .done(done), .found(found), .err(err),
        .hit_ofs(hit_ofs), .prev_ofs(prev_ofs)
    );

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_hdr(logic [15:0] id, logic [3:0] ver, logic [11:0] nxt);
        return {nxt, ver, id};
    endfunction

    task automatic put(logic [11:0] ofs, logic [31:0] w);
        mem[ofs[11:2]] = w;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = '0;
    endtask

    function automatic bit link_ok(logic [11:0] n);
        return (n[1:0] == 2'b00) && (n >= 12'h100) && (n <= 12'hFF8);
    endfunction

    // Expected outcome computed from the requirements.
    task automatic ref_walk(input logic [15:0] id, output logic e_found, output logic e_err,
                            output logic [11:0] e_hit, output logic [11:0] e_prev, output int e_n);
        logic [11:0] cur;
        logic [11:0] prv;
        logic [31:0] h;
        bit fin;
        cur = 12'h100; prv = '0; e_n = 0; fin = 0;
        e_found = 0; e_err = 0; e_hit = '0; e_prev = '0;
        while (!fin) begin
            e_n++;
            h = mem[cur[11:2]];
            if (e_n == 1 && h == '0) fin = 1;
            else if ((id == 0) ? (h[31:20] == 0) : (h[15:0] == id)) begin
                e_found = 1; e_hit = cur; e_prev = prv; fin = 1;
            end else if (h[31:20] == 0) begin
                e_prev = cur; fin = 1;
            end else if (!link_ok(h[31:20]) || e_n == MAX_VIS) begin
                e_err = 1; e_hit = cur; e_prev = prv; fin = 1;
            end else begin
                prv = cur; cur = h[31:20];
            end
        end
    endtask

    task automatic run_req(string rq, logic [15:0] id, bit poke);
        logic ef, ee;
        logic [11:0] eh, ep;
        int en;
        int cyc;
        ref_walk(id, ef, ee, eh, ep, en);
        @(negedge clk);
        req_valid = 1'b1; req_id = id;
        @(negedge clk);
        req_valid = 1'b0; cyc = 1;
        while (!done && cyc < WAIT_CAP) begin
            if (poke && cyc == 2) begin req_valid = 1'b1; req_id = ~id; end
            else req_valid = 1'b0;
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        if (!done) begin
            chk("R9", "done never rose", 32'd0, 32'd1);
            return;
        end
        chk("R9", "latency", cyc, 2 * en + 1);
        chk(rq, "found", found, ef);
        chk(rq, "err", err, ee);
        chk(rq, "hit_ofs", hit_ofs, eh);
        chk(rq, "prev_ofs", prev_ofs, ep);
        @(negedge clk);
        chk("R9", "done pulse width", done, 1'b0);
        chk("R10", "result held", {found, err, hit_ofs, prev_ofs}, {ef, ee, eh, ep});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic ef, ee;
        logic [11:0] eh, ep;
        int en;
        void'($urandom(32'd1234));
        clear_mem();
        rst_n = 1'b0; req_valid = 1'b0; req_id = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset outputs", {busy, done, found, err, mem_rd_en}, 5'b0);
        chk("R1", "reset offsets", {hit_ofs, prev_ofs}, 24'h0);

        // R3 empty list, normal and tail search
        run_req("R3", 16'h0001, 0);
        run_req("R3", 16'h0000, 0);

        // R4 R5 R6 R2 three-entry list
        put(12'h100, mk_hdr(16'h0001, 4'h1, 12'h180));
        put(12'h180, mk_hdr(16'h000D, 4'h2, 12'h2A0));
        put(12'h2A0, mk_hdr(16'h0010, 4'hF, 12'h000));
        run_req("R4", 16'h0001, 0);
        run_req("R4", 16'h0010, 0);
        run_req("R5", 16'h0003, 0);
        run_req("R2", 16'h000F, 0);
        run_req("R6", 16'h0000, 0);
        run_req("R10", 16'h000D, 1);
        run_req("R10", 16'h0001, 1);

        // R6 deleted head entry with ID 0 but a live link
        clear_mem();
        put(12'h100, mk_hdr(16'h0000, 4'h0, 12'h140));
        put(12'h140, mk_hdr(16'h0007, 4'h1, 12'h000));
        run_req("R6", 16'h0000, 0);

        // R7 misaligned link; match wins over the bad link (R4)
        clear_mem();
        put(12'h100, mk_hdr(16'h0001, 4'h1, 12'h182));
        run_req("R7", 16'h0005, 0);
        run_req("R4", 16'h0001, 0);

        // R7 link below the window
        put(12'h100, mk_hdr(16'h0001, 4'h1, 12'h040));
        run_req("R7", 16'h0009, 0);

        // R7 link above the window, then the legal top boundary
        put(12'h100, mk_hdr(16'h0001, 4'h1, 12'h200));
        put(12'h200, mk_hdr(16'h0002, 4'h1, 12'hFFC));
        run_req("R7", 16'h0009, 0);
        put(12'h200, mk_hdr(16'h0002, 4'h1, 12'hFF8));
        put(12'hFF8, mk_hdr(16'h0022, 4'h3, 12'h000));
        run_req("R7", 16'h0022, 0);

        // R8 cyclic list hits the visit limit
        clear_mem();
        put(12'h100, mk_hdr(16'h0001, 4'h1, 12'h200));
        put(12'h200, mk_hdr(16'h0002, 4'h1, 12'h100));
        run_req("R8", 16'h7777, 0);

        // Random chains with present, absent and tail searches
        for (int t = 0; t < 40; t++) begin
            int k;
            int stride;
            logic [11:0] offs [8];
            clear_mem();
            k = 1 + int'($urandom % 8);
            stride = 1 + 2 * int'($urandom % 50);
            if (stride % 7 == 0) stride += 2;
            for (int i = 0; i < 8; i++) offs[i] = 12'h100 + 12'(((i * stride) % 959) * 4);
            for (int i = 0; i < k; i++) begin
                logic [11:0] nx;
                nx = (i == k - 1) ? 12'h000 : offs[i + 1];
                put(offs[i], mk_hdr(16'(1 + $urandom % 12), 4'($urandom), nx));
            end
            for (int s = 0; s < 4; s++) begin
                logic [15:0] id;
                string tag;
                case (s)
                    0: id = mem[offs[$urandom % k][11:2]][15:0];
                    1: id = 16'(1 + $urandom % 16);
                    2: id = 16'h0000;
                    default: id = 16'(1 + $urandom % 12);
                endcase
                ref_walk(id, ef, ee, eh, ep, en);
                if (ee) tag = "R7";
                else if (ef && id == 0) tag = "R6";
                else if (ef) tag = "R4";
                else tag = "R5";
                run_req(tag, id, 0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule